// File: doc/BRIEF.md
# Pseudo-Associative Read Cache

This block is a read-only cache built from a power-of-two number of single-block frames. It behaves like a two-way cache, but the two candidate locations of a block are probed one after the other instead of in parallel. Every block has a home frame, given by the low bits of its block address, and an alternate frame, which is the home frame with the top index bit inverted. The home frame is checked on the first cycle after a request is accepted. The alternate frame is checked on the second cycle only if the home frame does not match. A match in the home frame is a fast hit, and a match in the alternate frame is a slow hit.

After a slow hit, the contents of the two frames are exchanged, so the next access to the same block is fast. On a miss, the block is fetched from memory as a burst of words. The old contents of the home frame move to the alternate frame, the previous contents of the alternate frame are dropped, and the new block is written into the home frame. A processor-side port takes one request at a time and returns a response with hit, fast and slow flags. A memory-side port issues a one-cycle block request and accepts the returned words in order.

Top module: `pac_cache`

## Requirements
- R1: With word address `a`, the block address is `a[ADDR_W-1:OFF_W]` and the word offset is `a[OFF_W-1:0]`. The home frame is the block address modulo FRAMES (its low IDX_W bits), and the alternate frame is the home frame with its most significant index bit inverted.
- R2: A fast hit (home frame valid and its tag matching) drives `rsp_valid`=1, `rsp_hit`=1, `rsp_fast`=1 and `rsp_slow`=0 on the first cycle after acceptance, with `rsp_data` set to the word at the requested offset.
- R3: When the home frame does not match and the alternate frame does, the block drives `rsp_valid`=1, `rsp_hit`=1, `rsp_slow`=1 and `rsp_fast`=0 on the second cycle after acceptance, with the requested word.
- R4: After a slow hit, the home and alternate frames have exchanged contents. The next access to that block is a fast hit, and the block that was displaced from the home frame now gives a slow hit.
- R5: On a miss, `mem_req` is high for exactly one cycle, the second cycle after acceptance, with `mem_blk` set to the block address. The next LINE_WORDS beats on `mem_rvalid` are taken as words 0 to LINE_WORDS-1, in that order. The response comes on the cycle after the last beat is taken, with `rsp_hit`, `rsp_fast` and `rsp_slow` all 0 and `rsp_data` set to the requested word.
- R6: A miss moves the old home-frame block into the alternate frame, drops the old alternate-frame block, and places the new block in the home frame.
- R7: Each tag holds the full block address, so two different blocks that share a frame pair never match each other.
- R8: Reset clears every valid bit. An invalid frame never matches, so the first read of any block after reset is a miss.
- R9: `req_ready` is 1 only while the block is idle. It is 0 from the cycle after acceptance through the response cycle, and all frame updates are complete before it returns to 1. `mem_req` is never high for a hit.
- R10: During reset and after its synchronised release, `rsp_valid`=0 and `mem_req`=0. `req_ready`=1 once the release has passed through the synchroniser.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Read request present |
| req_addr | input | ADDR_W | Word address of the read |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_data | output | WORD_W | Requested word |
| rsp_hit | output | 1 | Response came from a frame (fast or slow) |
| rsp_fast | output | 1 | Hit in the home frame |
| rsp_slow | output | 1 | Hit in the alternate frame |
| mem_req | output | 1 | One-cycle request for a block fill |
| mem_blk | output | ADDR_W-OFF_W | Block address of the fill |
| mem_rvalid | input | 1 | Fill word present |
| mem_rdata | input | WORD_W | Fill word, delivered in ascending word order |

## Verification
A wrong exchange or a wrong relocation inside the frame store does not show up when it happens. It shows up on a later access to one of the two blocks sharing that frame pair, as a hit of the wrong speed or as an extra miss. The vector sequence therefore repeatedly sends three blocks that share one frame pair and checks the hit kind of every access against the placement rules, so a wrong frame state is reported at most two accesses after it arises. A wrong word, a wrong offset or a wrong fill order shows up at once as a data mismatch, because every memory word encodes its own block and offset. A latency error in the probe or fill sequencing shows up at once in the cycle count of the affected response.

// File: rtl/pac_pkg.sv
package pac_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_PRI  = 3'd1,
    ST_SEC  = 3'd2,
    ST_FILL = 3'd3,
    ST_RESP = 3'd4
  } pac_state_e;
endpackage

// File: rtl/pac_probe.sv
// Tag comparison for one frame. An invalid frame never matches.
module pac_probe #(
  parameter int BLK_W = 14
) (
  input  logic             valid,
  input  logic [BLK_W-1:0] stored,
  input  logic [BLK_W-1:0] want,
  output logic             hit
);
  always_comb hit = valid && (stored == want);
endmodule

// File: rtl/pac_frames.sv
// Frame store. Both update kinds (exchange, fill-with-relocate) touch only
// the home/alternate pair of the current request.
module pac_frames #(
  parameter int FRAMES = 16,
  parameter int BLK_W  = 14,
  parameter int LINE_W = 128
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [$clog2(FRAMES)-1:0] pri_idx,
  input  logic [$clog2(FRAMES)-1:0] sec_idx,
  input  logic                      do_swap,
  input  logic                      do_fill,
  input  logic [BLK_W-1:0]          fill_tag,
  input  logic [LINE_W-1:0]         fill_line,
  output logic                      pri_v,
  output logic [BLK_W-1:0]          pri_tag,
  output logic [LINE_W-1:0]         pri_line,
  output logic                      sec_v,
  output logic [BLK_W-1:0]          sec_tag,
  output logic [LINE_W-1:0]         sec_line
);
  localparam int IDX_W = $clog2(FRAMES);

  logic              vld_q  [FRAMES];
  logic [BLK_W-1:0]  tag_q  [FRAMES];
  logic [LINE_W-1:0] line_q [FRAMES];

  always_comb begin
    pri_v    = vld_q[pri_idx];
    pri_tag  = tag_q[pri_idx];
    pri_line = line_q[pri_idx];
    sec_v    = vld_q[sec_idx];
    sec_tag  = tag_q[sec_idx];
    sec_line = line_q[sec_idx];
  end

  for (genvar f = 0; f < FRAMES; f++) begin : g_frame
    logic              is_pri, is_sec, wr_en, v_nx;
    logic [BLK_W-1:0]  t_nx;
    logic [LINE_W-1:0] l_nx;

    always_comb begin
      is_pri = (pri_idx == IDX_W'(f));
      is_sec = (sec_idx == IDX_W'(f));
      wr_en  = (do_swap || do_fill) && (is_pri || is_sec);
      v_nx   = vld_q[f];
      t_nx   = tag_q[f];
      l_nx   = line_q[f];
      if (is_pri && do_fill) begin
        v_nx = 1'b1;
        t_nx = fill_tag;
        l_nx = fill_line;
      end else if (is_pri && do_swap) begin
        v_nx = sec_v;
        t_nx = sec_tag;
        l_nx = sec_line;
      end else if (is_sec) begin
        v_nx = pri_v;
        t_nx = pri_tag;
        l_nx = pri_line;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     vld_q[f] <= 1'b0;
      else if (wr_en) vld_q[f] <= v_nx;
    end

    always_ff @(posedge clk) begin
      if (wr_en) begin
        tag_q[f]  <= t_nx;
        line_q[f] <= l_nx;
      end
    end
  end
endmodule

// File: rtl/pac_ctrl.sv
// Sequencer: home probe, alternate probe, burst fill, miss response.
module pac_ctrl import pac_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  input  logic [ADDR_W-1:0]            req_addr,
  input  logic                         pri_hit,
  input  logic                         sec_hit,
  input  logic                         mem_rvalid,
  input  logic [WORD_W-1:0]            mem_rdata,
  output pac_state_e                   state,
  output logic [ADDR_W-1:0]            addr_q,
  output logic [LINE_WORDS*WORD_W-1:0] fill_line,
  output logic                         do_swap,
  output logic                         do_fill,
  output logic                         mem_req
);
  localparam int BEAT_W = $clog2(LINE_WORDS);
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(LINE_WORDS - 1);

  pac_state_e        state_q, state_d;
  logic [BEAT_W-1:0] beat_q;
  logic              ld_addr, beat_clr, beat_inc;
  logic [WORD_W-1:0] fill_buf [LINE_WORDS];

  always_comb begin
    state_d  = state_q;
    do_swap  = 1'b0;
    do_fill  = 1'b0;
    mem_req  = 1'b0;
    ld_addr  = 1'b0;
    beat_clr = 1'b0;
    beat_inc = 1'b0;
    case (state_q)
      ST_IDLE: if (req_valid) begin
        ld_addr = 1'b1;
        state_d = ST_PRI;
      end
      ST_PRI:  state_d = pri_hit ? ST_IDLE : ST_SEC;
      ST_SEC:  if (sec_hit) begin
        do_swap = 1'b1;
        state_d = ST_IDLE;
      end else begin
        mem_req  = 1'b1;
        beat_clr = 1'b1;
        state_d  = ST_FILL;
      end
      ST_FILL: if (mem_rvalid) begin
        beat_inc = 1'b1;
        if (beat_q == LAST_BEAT) state_d = ST_RESP;
      end
      ST_RESP: begin
        do_fill = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_clr)      beat_q <= '0;
      else if (beat_inc) beat_q <= beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (ld_addr) addr_q <= req_addr;
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_word
    always_ff @(posedge clk) begin
      if (beat_inc && beat_q == BEAT_W'(w)) fill_buf[w] <= mem_rdata;
    end
    assign fill_line[w*WORD_W +: WORD_W] = fill_buf[w];
  end

  assign state = state_q;

  // R5: the miss response state is entered only right after a fill beat
  assert_resp_after_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RESP) |-> $past(mem_rvalid));
endmodule

// File: rtl/pac_cache.sv
module pac_cache import pac_pkg::*; #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int FRAMES     = 16,
  parameter int LINE_WORDS = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   req_valid,
  input  logic [ADDR_W-1:0]                      req_addr,
  output logic                                   req_ready,
  output logic                                   rsp_valid,
  output logic [WORD_W-1:0]                      rsp_data,
  output logic                                   rsp_hit,
  output logic                                   rsp_fast,
  output logic                                   rsp_slow,
  output logic                                   mem_req,
  output logic [ADDR_W-$clog2(LINE_WORDS)-1:0]   mem_blk,
  input  logic                                   mem_rvalid,
  input  logic [WORD_W-1:0]                      mem_rdata
);
  localparam int OFF_W  = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(FRAMES);
  localparam int BLK_W  = ADDR_W - OFF_W;
  localparam int LINE_W = LINE_WORDS * WORD_W;
  localparam logic [IDX_W-1:0] IDX_TOP = IDX_W'(1) << (IDX_W - 1);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  pac_state_e        state;
  logic [ADDR_W-1:0] addr_q;
  logic [BLK_W-1:0]  blk_q;
  logic [OFF_W-1:0]  off_q;
  logic [IDX_W-1:0]  pri_idx, sec_idx;
  logic              pri_v, sec_v, pri_hit, sec_hit, do_swap, do_fill;
  logic [BLK_W-1:0]  pri_tag, sec_tag;
  logic [LINE_W-1:0] pri_line, sec_line, fill_line, sel_line;
  logic [WORD_W-1:0] sel_words [LINE_WORDS];

  assign blk_q   = addr_q[ADDR_W-1:OFF_W];
  assign off_q   = addr_q[OFF_W-1:0];
  assign pri_idx = blk_q[IDX_W-1:0];
  assign sec_idx = pri_idx ^ IDX_TOP;

  pac_ctrl #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)) u_ctrl (
    .clk(clk), .rst_n(rst_core_n), .req_valid(req_valid), .req_addr(req_addr),
    .pri_hit(pri_hit), .sec_hit(sec_hit), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .state(state), .addr_q(addr_q), .fill_line(fill_line),
    .do_swap(do_swap), .do_fill(do_fill), .mem_req(mem_req));

  pac_frames #(.FRAMES(FRAMES), .BLK_W(BLK_W), .LINE_W(LINE_W)) u_frames (
    .clk(clk), .rst_n(rst_core_n), .pri_idx(pri_idx), .sec_idx(sec_idx),
    .do_swap(do_swap), .do_fill(do_fill), .fill_tag(blk_q), .fill_line(fill_line),
    .pri_v(pri_v), .pri_tag(pri_tag), .pri_line(pri_line),
    .sec_v(sec_v), .sec_tag(sec_tag), .sec_line(sec_line));

  pac_probe #(.BLK_W(BLK_W)) u_probe_pri (
    .valid(pri_v), .stored(pri_tag), .want(blk_q), .hit(pri_hit));
  pac_probe #(.BLK_W(BLK_W)) u_probe_sec (
    .valid(sec_v), .stored(sec_tag), .want(blk_q), .hit(sec_hit));

  always_comb begin
    if (state == ST_SEC)       sel_line = sec_line;
    else if (state == ST_RESP) sel_line = fill_line;
    else                       sel_line = pri_line;
  end

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_sel
    assign sel_words[w] = sel_line[w*WORD_W +: WORD_W];
  end

  always_comb begin
    req_ready = (state == ST_IDLE);
    rsp_fast  = (state == ST_PRI) && pri_hit;
    rsp_slow  = (state == ST_SEC) && sec_hit;
    rsp_hit   = rsp_fast || rsp_slow;
    rsp_valid = rsp_hit || (state == ST_RESP);
    rsp_data  = sel_words[off_q];
    mem_blk   = blk_q;
  end

  // R2: a fast hit answers on the cycle right after acceptance
  assert_fast_latency_R2: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_fast |-> $past(req_valid && req_ready));

  // R3: a slow hit follows a failed home probe
  assert_slow_order_R3: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_slow |-> ($past(state) == ST_PRI && !$past(pri_hit)));

  // R4: slow hit leaves the pair exchanged
  assert_swap_pair_R4: assert property (@(posedge clk) disable iff (!rst_core_n)
    rsp_slow |=> (pri_v && pri_tag == $past(sec_tag) &&
                  sec_v == $past(pri_v) && sec_tag == $past(pri_tag)));

  // R6: fill places new block home and relocates the old home block
  assert_fill_place_R6: assert property (@(posedge clk) disable iff (!rst_core_n)
    (state == ST_RESP) |=> (pri_v && pri_tag == $past(blk_q) &&
                            sec_v == $past(pri_v) && sec_tag == $past(pri_tag)));

  // R9: busy right after acceptance, no fill request on a hit
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    (req_valid && req_ready) |=> !req_ready);
  assert_no_fill_on_hit_R9: assert property (@(posedge clk) disable iff (!rst_core_n)
    mem_req |-> !rsp_valid);
endmodule

// File: tb/pac_cache_test.sv
`timescale 1ns/1ps
module pac_cache_test;
  localparam int K_MISS = 0, K_FAST = 1, K_SLOW = 2;
  localparam int N = 19;
  // Blocks A=0x001, B=0x011 (home frame 1), C=0x009 (home frame 9): one pair (R1, R7)
  localparam logic [15:0] T_ADDR [N] = '{
    16'h0004, 16'h0007, 16'h0045, 16'h0006, 16'h0005, 16'h0044, 16'h0026,
    16'h0047, 16'h0004, 16'h0025, 16'h0027, 16'h0046, 16'h0004, 16'hFFFF,
    16'hFFFC, 16'h0009, 16'h000A, 16'h0045, 16'h0045};
  localparam int T_KIND [N] = '{
    K_MISS, K_FAST, K_MISS, K_SLOW, K_FAST, K_SLOW, K_MISS,
    K_MISS, K_SLOW, K_MISS, K_FAST, K_FAST, K_MISS, K_MISS,
    K_FAST, K_MISS, K_FAST, K_SLOW, K_FAST};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_ready, rsp_valid, rsp_hit, rsp_fast, rsp_slow, mem_req;
  logic [31:0] rsp_data;
  logic [13:0] mem_blk;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  int          errors = 0, checks = 0;
  int          cycles = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  pac_cache uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .rsp_hit(rsp_hit), .rsp_fast(rsp_fast), .rsp_slow(rsp_slow),
    .mem_req(mem_req), .mem_blk(mem_blk), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata));

  // every memory word encodes its own address
  function automatic logic [31:0] mword(input logic [15:0] a);
    return {~a, a};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", rq, act, exp);
    end
  endtask

  task automatic do_read(input logic [15:0] a, input int kind);
    int cyc, bi, exp_lat;
    bit got, pend, sawreq;
    logic [13:0] mblk;
    string rq;
    rq = (kind == K_FAST) ? "R2" : (kind == K_SLOW) ? "R3 R4" : "R5 R6";
    exp_lat = (kind == K_FAST) ? 1 : (kind == K_SLOW) ? 2 : 7;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9 ready idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy", 64'(req_ready), 64'd0);
    cyc = 1; got = 0; pend = 0; bi = 0; sawreq = 0; mblk = '0;
    while (!got && cyc < 64) begin
      mem_rvalid = 1'b0;
      if (rsp_valid) got = 1;
      else begin
        if (mem_req) begin
          sawreq = 1; mblk = mem_blk; pend = 1; bi = 0;
        end else if (pend && bi < 4) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mword({mblk, 2'(bi)});
          bi++;
        end
        @(negedge clk);
        cyc++;
      end
    end
    mem_rvalid = 1'b0;
    chk(got && cyc == exp_lat, {rq, " latency"}, 64'(cyc), 64'(exp_lat));
    chk(rsp_data == mword(a), {rq, " data"}, 64'(rsp_data), 64'(mword(a)));
    chk({rsp_hit, rsp_fast, rsp_slow} ==
        ((kind == K_FAST) ? 3'b110 : (kind == K_SLOW) ? 3'b101 : 3'b000),
        {rq, " flags"}, 64'({rsp_hit, rsp_fast, rsp_slow}),
        64'((kind == K_FAST) ? 3'b110 : (kind == K_SLOW) ? 3'b101 : 3'b000));
    chk(sawreq == (kind == K_MISS), "R9 R5 fill request", 64'(sawreq),
        64'(kind == K_MISS));
    if (kind == K_MISS)
      chk(mblk == a[15:2], "R5 R1 block address", 64'(mblk), 64'(a[15:2]));
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R9 ready return", 64'({req_ready, rsp_valid}),
        64'(2'b10));
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        errors++; checks++;
        $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
      end
    end
  end

  initial begin : main
    // R10: outputs during reset
    repeat (3) @(negedge clk);
    chk(!rsp_valid && !mem_req, "R10 in reset", 64'({rsp_valid, mem_req}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req, "R10 after release",
        64'({req_ready, rsp_valid, mem_req}), 64'(3'b100));

    // vector walk: R1 R2 R3 R4 R5 R6 R7 (first access of each block is R8)
    for (int i = 0; i < N; i++) do_read(T_ADDR[i], T_KIND[i]);

    // R8: reset mid-run drops every block
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk(!rsp_valid && !mem_req, "R10 reset again", 64'({rsp_valid, mem_req}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    do_read(16'h0045, K_MISS);   // R8: previously cached block misses
    do_read(16'h0004, K_MISS);   // R8
    do_read(16'h0046, K_SLOW);   // R6: B relocated to alternate frame
    do_read(16'h0004, K_SLOW);   // R4: A displaced by exchange

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule